// File: doc/BRIEF.md
# Logic Cluster Local Interconnect with Carry Chain

This block is the local routing of a cluster of ten logic elements. Each of the sixty element input pins (six per element) has its own 6-bit source select. A select can pick any of the forty general cluster inputs, or any of the twenty element outputs fed back into the cluster. The block also gathers the element outputs onto the twenty-bit cluster output bus. It runs a carry chain through the elements in index order, and it fans the cluster clock out to every element.

The logic elements sit outside the block behind a flat port interface. The block drives sixty pins toward the elements and receives twenty outputs and ten carry-outs back from them. All selects sit in one 360-bit configuration register. That register takes a new image only on a rising clock edge with the configuration enable high. Every path from an input to an element pin, a cluster output or a carry is combinational.

Top module: `lcl_interconnect`

## Requirements
- R1: After reset every pin select holds code 63, so all sixty element pins read 0 whatever the inputs are.
- R2: The configuration register takes `cfgData` on a rising clock edge only when `cfgEn` is high. With `cfgEn` low it keeps its value, and so the pin routing does not change.
- R3: Pin p is element p/6, input p%6, and it drives `elemPin[p]`. Its select is `cfgData[6p+5:6p]`.
- R4: A select code c from 0 to 39 drives the pin from `clusterIn[c]`.
- R5: A select code c from 40 to 59 drives the pin from feedback bit c-40, taken from the cluster output bus (`clusterOut[c-40]`).
- R6: Select codes 60 to 63 drive the pin to 0.
- R7: `clusterOut[i]` equals output 0 of element i, and `clusterOut[10+i]` equals output 1 of element i, for i from 0 to 9. Output o of element e arrives on `elemOut[2e+o]`.
- R8: `elemCarryIn[0]` equals `carryIn`, `elemCarryIn[i+1]` equals `elemCarryOut[i]` for i from 0 to 8, and `carryOut` equals `elemCarryOut[9]`.
- R9: Every bit of `elemClk` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rstN | input | 1 | Active-low asynchronous reset of the configuration register |
| cfgEn | input | 1 | Configuration load enable |
| cfgData | input | 360 | Configuration image, six select bits per pin |
| clusterIn | input | 40 | General cluster inputs |
| carryIn | input | 1 | Carry into the chain, goes to element 0 |
| elemOut | input | 20 | Element outputs, element e output o at bit 2e+o |
| elemCarryOut | input | 10 | Carry-out of each element |
| elemPin | output | 60 | Element input pins, pin 6e+j is element e input j |
| elemCarryIn | output | 10 | Carry-in of each element |
| elemClk | output | 10 | Clock to each element |
| clusterOut | output | 20 | Cluster output bus |
| carryOut | output | 1 | Carry out of the chain, from element 9 |

## Verification
A configuration load and a change of the routed data can fall in the same cycle. The bench raises `cfgEn` with a new image in the same half-cycle in which it changes `clusterIn`. Just before the edge it checks that the pins show the new data through the old selects. After the edge it checks that the pins show the new data through the new selects. A second case changes the fed-back element outputs while the enable stays low, and checks that the feedback follows at once while the routing stays put.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
  } lclStrobes_t;
endpackage

// File: rtl/lcl_ctrl.sv
module lcl_ctrl
  import lcl_pkg::*;
(
  input  logic        cfgEn,
  output lclStrobes_t stb
);
  // The configuration image is taken whenever the enable is high at an edge.
  always_comb begin
    stb.load = cfgEn;
  end
endmodule

// File: rtl/lcl_datapath.sv
module lcl_datapath
  import lcl_pkg::*;
#(
  parameter int NUM_ELEM  = 10,
  parameter int ELEM_INS  = 6,
  parameter int ELEM_OUTS = 2,
  parameter int NUM_CIN   = 40
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  lclStrobes_t                       stb,
  input  logic [NUM_ELEM*ELEM_INS*$clog2(NUM_CIN+NUM_ELEM*ELEM_OUTS)-1:0] cfgData,
  input  logic [NUM_CIN-1:0]                clusterIn,
  input  logic [NUM_ELEM*ELEM_OUTS-1:0]     elemOut,
  input  logic [NUM_ELEM-1:0]               elemCarryOut,
  input  logic                              carryIn,
  output logic [NUM_ELEM*ELEM_INS-1:0]      elemPin,
  output logic [NUM_ELEM*ELEM_OUTS-1:0]     clusterOut,
  output logic [NUM_ELEM-1:0]               elemCarryIn,
  output logic                              carryOut
);
  localparam int NUM_PINS = NUM_ELEM * ELEM_INS;
  localparam int NUM_FB   = NUM_ELEM * ELEM_OUTS;
  localparam int NUM_SRC  = NUM_CIN + NUM_FB;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int PAD_W    = 1 << SEL_W;
  localparam int CFG_W    = NUM_PINS * SEL_W;

  logic [CFG_W-1:0] cfgReg;
  logic [PAD_W-1:0] srcPad;

  // Configuration register: reset to all-ones (every pin unused).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cfgReg <= '1;
    else if (stb.load) cfgReg <= cfgData;
  end

  // R2: held without the load strobe, captured with it.
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(cfgReg));
  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> cfgReg == $past(cfgData));

  // Output bus gathers output o of element e at position o*NUM_ELEM+e.
  for (genvar o = 0; o < ELEM_OUTS; o++) begin : g_outIdx
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_outElem
      assign clusterOut[o*NUM_ELEM+e] = elemOut[e*ELEM_OUTS+o];
    end
  end

  // Source vector: cluster inputs, then feedback, then zero padding.
  assign srcPad = {{(PAD_W-NUM_SRC){1'b0}}, clusterOut, clusterIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SEL_W-1:0] sel;
    assign sel        = cfgReg[p*SEL_W +: SEL_W];
    assign elemPin[p] = srcPad[sel];

    // R4: low codes route a general input.
    a_r4_direct_input: assert property (@(posedge clk) disable iff (!rstN)
      (int'(sel) < NUM_CIN) |-> elemPin[p] == clusterIn[int'(sel)]);
    // R5: middle codes route the matching element output.
    a_r5_feedback: assert property (@(posedge clk) disable iff (!rstN)
      (int'(sel) >= NUM_CIN && int'(sel) < NUM_SRC) |->
        elemPin[p] == elemOut[((int'(sel)-NUM_CIN) % NUM_ELEM)*ELEM_OUTS
                              + (int'(sel)-NUM_CIN) / NUM_ELEM]);
    // R6: unused codes give 0.
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
      (int'(sel) >= NUM_SRC) |-> !elemPin[p]);
  end

  // R8: carry chain from element 0 upward.
  assign elemCarryIn = {elemCarryOut[NUM_ELEM-2:0], carryIn};
  assign carryOut    = elemCarryOut[NUM_ELEM-1];
endmodule

// File: rtl/lcl_interconnect.sv
module lcl_interconnect
  import lcl_pkg::*;
#(
  parameter int NUM_ELEM  = 10,
  parameter int ELEM_INS  = 6,
  parameter int ELEM_OUTS = 2,
  parameter int NUM_CIN   = 40,
  localparam int SEL_W    = $clog2(NUM_CIN + NUM_ELEM*ELEM_OUTS),
  localparam int CFG_W    = NUM_ELEM * ELEM_INS * SEL_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgEn,
  input  logic [CFG_W-1:0]              cfgData,
  input  logic [NUM_CIN-1:0]            clusterIn,
  input  logic                          carryIn,
  input  logic [NUM_ELEM*ELEM_OUTS-1:0] elemOut,
  input  logic [NUM_ELEM-1:0]           elemCarryOut,
  output logic [NUM_ELEM*ELEM_INS-1:0]  elemPin,
  output logic [NUM_ELEM-1:0]           elemCarryIn,
  output logic [NUM_ELEM-1:0]           elemClk,
  output logic [NUM_ELEM*ELEM_OUTS-1:0] clusterOut,
  output logic                          carryOut
);
  lclStrobes_t stb;

  lcl_ctrl u_ctrl (
    .cfgEn (cfgEn),
    .stb   (stb)
  );

  lcl_datapath #(
    .NUM_ELEM  (NUM_ELEM),
    .ELEM_INS  (ELEM_INS),
    .ELEM_OUTS (ELEM_OUTS),
    .NUM_CIN   (NUM_CIN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgData      (cfgData),
    .clusterIn    (clusterIn),
    .elemOut      (elemOut),
    .elemCarryOut (elemCarryOut),
    .carryIn      (carryIn),
    .elemPin      (elemPin),
    .clusterOut   (clusterOut),
    .elemCarryIn  (elemCarryIn),
    .carryOut     (carryOut)
  );

  // R9: clock fan-out to every element.
  assign elemClk = {NUM_ELEM{clk}};
endmodule

// File: tb/lcl_interconnect_tb.sv
module lcl_interconnect_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgEn = 1'b0;
  logic [359:0] cfgData = '0;
  logic [39:0]  clusterIn = '0;
  logic         carryIn = 1'b0;
  logic [19:0]  elemOut = '0;
  logic [9:0]   elemCarryOut = '0;
  logic [59:0]  elemPin;
  logic [9:0]   elemCarryIn;
  logic [9:0]   elemClk;
  logic [19:0]  clusterOut;
  logic         carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  lcl_interconnect u_dut (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgData(cfgData),
    .clusterIn(clusterIn), .carryIn(carryIn), .elemOut(elemOut),
    .elemCarryOut(elemCarryOut), .elemPin(elemPin), .elemCarryIn(elemCarryIn),
    .elemClk(elemClk), .clusterOut(clusterOut), .carryOut(carryOut)
  );

  // Vector: base code, code stride, cluster inputs, element outputs, carry-outs, carry-in.
  localparam int NV = 6;
  localparam logic [82:0] VECS [NV] = '{
    {6'd0,  6'd1,  40'hA5_C3F0_1E96, 20'h5_A3C1, 10'h2B5, 1'b1},
    {6'd40, 6'd1,  40'h12_3456_789A, 20'hF_0F0F, 10'h155, 1'b0},
    {6'd60, 6'd0,  40'hFF_FFFF_FFFF, 20'hF_FFFF, 10'h3FF, 1'b1},
    {6'd7,  6'd13, 40'h0F_F00F_F00F, 20'hA_5A5A, 10'h0F0, 1'b1},
    {6'd45, 6'd5,  40'h80_0000_0001, 20'h8_0001, 10'h201, 1'b0},
    {6'd39, 6'd21, 40'h5E_ADBE_EF11, 20'h3_C96A, 10'h3C3, 1'b0}
  };

  function automatic logic [359:0] mkCfg(input logic [5:0] base, input logic [5:0] stride);
    logic [359:0] c;
    for (int p = 0; p < 60; p++) c[p*6 +: 6] = 6'(base + 6'(p) * stride);
    return c;
  endfunction

  // Cluster output order from element outputs (R7 numbering).
  function automatic logic [19:0] expOut(input logic [19:0] eo);
    logic [19:0] r;
    for (int i = 0; i < 10; i++) begin
      r[i]      = eo[2*i];
      r[10 + i] = eo[2*i + 1];
    end
    return r;
  endfunction

  function automatic logic [59:0] expPins(input logic [359:0] c, input logic [39:0] ci,
                                          input logic [19:0] eo);
    logic [59:0] r;
    logic [19:0] fb;
    fb = expOut(eo);
    for (int p = 0; p < 60; p++) begin
      int code;
      code = int'(c[p*6 +: 6]);
      if (code < 40)      r[p] = ci[code];
      else if (code < 60) r[p] = fb[code - 40];
      else                r[p] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadCfg(input logic [359:0] c);
    @(negedge clk);
    cfgEn   = 1'b1;
    cfgData = c;
    @(negedge clk);
    cfgEn   = 1'b0;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [359:0] cfgA;
    logic [359:0] cfgB;
    clusterIn = '1;
    elemOut   = '1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, every pin reads zero with all inputs high.
    check("R1 reset pins", 64'(elemPin), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 after release", 64'(elemPin), 64'h0);

    // Table walk: R3 R4 R5 R6 R7 R8.
    for (int v = 0; v < NV; v++) begin
      logic [359:0] c;
      c = mkCfg(VECS[v][82:77], VECS[v][76:71]);
      loadCfg(c);
      clusterIn    = VECS[v][70:31];
      elemOut      = VECS[v][30:11];
      elemCarryOut = VECS[v][10:1];
      carryIn      = VECS[v][0];
      #1;
      check("R3 R4 R5 R6 pin routing", 64'(elemPin), 64'(expPins(c, clusterIn, elemOut)));
      check("R7 output mapping", 64'(clusterOut), 64'(expOut(elemOut)));
      check("R8 carry chain", 64'({carryOut, elemCarryIn}),
            64'({elemCarryOut[9], elemCarryOut[8:0], carryIn}));
    end

    // R2: new image with enable low has no effect on the pins.
    cfgA = mkCfg(6'd0, 6'd1);
    loadCfg(cfgA);
    @(negedge clk);
    cfgData   = mkCfg(6'd60, 6'd0);
    clusterIn = 40'hFF_FFFF_FFFF;
    elemOut   = 20'hF_FFFF;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R2 hold without enable", 64'(elemPin), 64'(expPins(cfgA, clusterIn, elemOut)));

    // R5 with enable low: feedback follows at once, routing stays.
    elemOut = 20'h0_0000;
    #1;
    check("R5 feedback tracks", 64'(elemPin), 64'(expPins(cfgA, clusterIn, elemOut)));

    // R2 same cycle: load and data change together.
    cfgB = mkCfg(6'd5, 6'd0);
    @(negedge clk);
    cfgEn     = 1'b1;
    cfgData   = cfgB;
    clusterIn = 40'h00_0000_0020;
    #1;
    check("R2 old routing before edge", 64'(elemPin), 64'(expPins(cfgA, clusterIn, elemOut)));
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    check("R2 new routing after edge", 64'(elemPin), 64'hFFF_FFFF_FFFF_FFFF);

    // R3: select field position, pin 59 alone to input 39.
    cfgB = '1;
    cfgB[359:354] = 6'd39;
    loadCfg(cfgB);
    clusterIn = 40'h80_0000_0000;
    #1;
    check("R3 field of pin 59", 64'(elemPin), 64'h800_0000_0000_0000);

    // R9: clock fan-out at both phases.
    @(posedge clk);
    #1;
    check("R9 clock high", 64'(elemClk), 64'h3FF);
    @(negedge clk);
    #1;
    check("R9 clock low", 64'(elemClk), 64'h0);

    // R1: reset again returns all pins to zero.
    rstN = 1'b0;
    #1;
    check("R1 reset clears routing", 64'(elemPin), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule